// File: doc/BRIEF.md
# Lock-Gated Clock Source Selector

This block chooses the clock that feeds a processor core. After reset the core runs straight off the crystal. Software can instead ask for a clock derived from an external PLL. The block keeps that request pending until it has seen a stable lock indication, and only then hands the core over to the PLL clock. The handover goes through a glitch-free two-sided multiplexer, so the core clock never shows a shortened pulse in either direction, and no reset is needed afterwards. If lock is lost, the core falls back to the crystal.

The block also produces the two clocks the external phase detector compares:
- the reference clock: the crystal, or the crystal halved, divided by a programmable factor;
- the feedback clock: the VCO clock divided by a second programmable factor.

A post-divider derives the PLL-side core clock from the VCO. All divider settings can be changed only while the crystal is actually driving the core. Writes made while the PLL is in use are dropped and flagged. Every accepted change restarts lock qualification, which is measured by a counter stepping on the divided reference.

All register access is synchronous to the crystal clock. The analog PLL and VCO sit outside the block. The VCO clock and a raw lock signal arrive as inputs.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset, `rd_data` reads all zeros and `cpu_clk` follows the crystal clock.
- R2: Control bit 1 (halve) set to 1 makes the reference divider count every second crystal cycle, doubling the reference period for the same divider field.
- R3: `ref_clk_out` has a period of (REF+2) input-clock cycles, with REF in bits [7:2]. The input clock is the crystal, or the crystal halved when bit 1 is set.
- R4: `fb_clk_out` has a period of (FB+2) VCO cycles, with FB in bits [13:8].
- R5: While the PLL source is active, `cpu_clk` has a period of VO*CD VCO cycles. VO is in bits [16:14] and CD in bits [19:17]. A product below 2 is treated as 2.
- R6: With control bit 0 at 0, `cpu_clk` runs at the crystal period.
- R7: Writing bit 0 to 1 requests the PLL source. The switch waits until the lock flag (read-only bit 31) is 1. A low raw lock clears the flag and returns `cpu_clk` to the crystal.
- R8: The source switch never shows both sources enabled at once, and never shows a `cpu_clk` pulse shorter than the shorter half period of the two sources.
- R9: A write that changes divider fields (bits [19:1]) while bit 0 is 1 or the crystal path is not yet live leaves the fields and `cpu_clk` unchanged. It sets the sticky error bit 30. Writing 1 to bit 30 clears it.
- R10: An accepted divider change clears the lock flag at once. It also restarts the lock and reference counters. With the raw lock held high and halve at 0, the flag returns exactly LOCK_CNT*(REF+2) crystal edges after the write edge.
- R11: `rd_data` reflects bit 0, bits [19:1] and bit 30 as stored, and bit 31 as the lock flag. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock; also clocks the register interface |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_vco | input | 1 | VCO clock from the external PLL |
| pll_lock_raw | input | 1 | Unsynchronized lock indication from the PLL |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| ref_clk_out | output | 1 | Divided reference clock to the phase detector |
| fb_clk_out | output | 1 | Divided VCO clock to the phase detector |
| cpu_clk | output | 1 | Selected core clock |

## Verification
A register write lands on the first crystal edge after the strobe, so readback checks sample at the following falling edge. The lock flag is checked at the exact edge count of R10: one edge before its due edge it must still read 0, and it must read 1 on the due edge. Clock periods do not depend on a single edge. They are measured as the time between rising edges, taken only after a settling gap of ten crystal cycles or several output edges, so a switch still in progress cannot be mistaken for the new period. A background monitor times every `cpu_clk` phase from reset release onward to catch runt pulses.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    localparam int REG_W    = 32;
    localparam int BYP_BIT  = 0;   // 1 = PLL source requested
    localparam int HALF_BIT = 1;   // 1 = crystal halved before reference divider
    localparam int FLD_LSB  = 2;   // first divider field
    localparam int ERR_BIT  = 30;  // sticky rejected-write flag, write 1 to clear
    localparam int LOCK_BIT = 31;  // read-only lock flag

    typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/clksel_refdiv.sv
`timescale 1ns/1ps
module clksel_refdiv #(
    parameter int DIV_W    = 6,
    parameter int LOCK_CNT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_sel,
    input  logic [DIV_W-1:0] ref_fld,
    input  logic             restart,
    input  logic             lock_raw,
    output logic             ref_tick,
    output logic             ref_clk,
    output logic             locked
);
    localparam int CNT_W = DIV_W + 1;
    localparam int LCK_W = $clog2(LOCK_CNT + 1);
    localparam logic [LCK_W-1:0] LCK_MAX = LCK_W'(LOCK_CNT);

    typedef struct packed {
        logic [1:0]       sync;
        logic             hp;
        logic [CNT_W-1:0] rc;
        logic             rclk;
        logic [LCK_W-1:0] lc;
        logic             lk;
    } st_t;

    st_t q, d;
    logic [CNT_W-1:0] modulus;
    logic             in_tick;
    logic             tick;

    always_comb begin
        d        = q;
        modulus  = CNT_W'(ref_fld) + CNT_W'(2);
        in_tick  = half_sel ? q.hp : 1'b1;
        tick     = in_tick && (q.rc >= modulus - CNT_W'(1));
        d.sync   = {q.sync[0], lock_raw};
        d.hp     = ~q.hp;
        if (in_tick) begin
            d.rc = tick ? '0 : q.rc + CNT_W'(1);
        end
        d.rclk = (d.rc < (modulus >> 1));
        // lock qualification on the divided reference
        if (!q.sync[1]) begin
            d.lc = '0;
            d.lk = 1'b0;
        end else if (tick && (q.lc != LCK_MAX)) begin
            d.lc = q.lc + LCK_W'(1);
            if (q.lc + LCK_W'(1) == LCK_MAX) begin
                d.lk = 1'b1;
            end
        end
        if (restart) begin
            d.hp   = 1'b0;
            d.rc   = '0;
            d.rclk = 1'b1;
            d.lc   = '0;
            d.lk   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ref_tick = tick;
    assign ref_clk  = q.rclk;
    assign locked   = q.lk;
endmodule

// File: rtl/clksel_vcodiv.sv
`timescale 1ns/1ps
module clksel_vcodiv #(
    parameter int DIV_W  = 6,
    parameter int POST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  fb_fld,
    input  logic [POST_W-1:0] vo_fld,
    input  logic [POST_W-1:0] cd_fld,
    output logic              fb_clk,
    output logic              pll_clk
);
    localparam int PROD_W = 2 * POST_W;
    localparam int CW     = (DIV_W + 1 > PROD_W) ? DIV_W + 1 : PROD_W;
    localparam int NDIV   = 2;   // index 0: feedback, index 1: post divider

    logic [PROD_W-1:0] prod;
    logic [CW-1:0]     mods [NDIV];
    logic [NDIV-1:0]   lvl;

    always_comb begin
        prod    = {{POST_W{1'b0}}, vo_fld} * {{POST_W{1'b0}}, cd_fld};
        mods[0] = CW'(fb_fld) + CW'(2);
        mods[1] = (prod < PROD_W'(2)) ? CW'(2) : CW'(prod);
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        typedef struct packed {
            logic [CW-1:0] cnt;
            logic          lv;
        } dst_t;
        dst_t q, d;

        always_comb begin
            d     = q;
            d.cnt = (q.cnt >= mods[g] - CW'(1)) ? '0 : q.cnt + CW'(1);
            d.lv  = (d.cnt < (mods[g] >> 1));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end

        assign lvl[g] = q.lv;
    end

    assign fb_clk  = lvl[0];
    assign pll_clk = lvl[1];
endmodule

// File: rtl/clksel_gfmux.sv
`timescale 1ns/1ps
module clksel_gfmux (
    input  logic xclk,
    input  logic pclk,
    input  logic rst_n,
    input  logic sel,
    output logic clk_out,
    output logic en_x,
    output logic en_p
);
    logic xs_q, xs_d;
    logic ps_q, ps_d;

    always_comb begin
        xs_d = ~sel & ~en_p;
        ps_d = sel & ~en_x;
    end

    // crystal side: capture on rising edge, enable on falling edge
    always_ff @(posedge xclk or negedge rst_n) begin
        if (!rst_n) begin
            xs_q <= 1'b1;
        end else begin
            xs_q <= xs_d;
        end
    end

    always_ff @(negedge xclk or negedge rst_n) begin
        if (!rst_n) begin
            en_x <= 1'b1;
        end else begin
            en_x <= xs_q;
        end
    end

    // PLL side: same structure in its own domain
    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= 1'b0;
        end else begin
            ps_q <= ps_d;
        end
    end

    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            en_p <= 1'b0;
        end else begin
            en_p <= ps_q;
        end
    end

    assign clk_out = (xclk & en_x) | (pclk & en_p);
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int DIV_W    = 6,
    parameter int POST_W   = 3,
    parameter int LOCK_CNT = 16
) (
    input  logic        clk_xtal,
    input  logic        rst_n,
    input  logic        clk_vco,
    input  logic        pll_lock_raw,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        ref_clk_out,
    output logic        fb_clk_out,
    output logic        cpu_clk
);
    localparam int REF_LSB = FLD_LSB;
    localparam int FB_LSB  = REF_LSB + DIV_W;
    localparam int VO_LSB  = FB_LSB + DIV_W;
    localparam int CD_LSB  = VO_LSB + POST_W;
    localparam int TOP_FLD = CD_LSB + POST_W;
    localparam int CFG_W   = 1 + 2 * DIV_W + 2 * POST_W;

    typedef struct packed {
        logic              half;
        logic [DIV_W-1:0]  refd;
        logic [DIV_W-1:0]  fbd;
        logic [POST_W-1:0] vo;
        logic [POST_W-1:0] cd;
    } cfg_t;

    typedef struct packed {
        logic req;
        logic err;
        cfg_t cfg;
    } st_t;

    st_t        q, d;
    cfg_t       wr_cfg;
    logic       restart;
    logic       in_byp;
    logic       locked;
    logic       ref_tick;
    logic       pll_clk;
    logic       sel;
    logic       en_x;
    logic       en_p;
    logic [CFG_W-1:0] cfg_bits;
    reg_word_t  rd_w;
    logic       unused_wr;

    always_comb begin
        d       = q;
        restart = 1'b0;
        wr_cfg  = '{half: wr_data[HALF_BIT],
                    refd: wr_data[REF_LSB +: DIV_W],
                    fbd:  wr_data[FB_LSB  +: DIV_W],
                    vo:   wr_data[VO_LSB  +: POST_W],
                    cd:   wr_data[CD_LSB  +: POST_W]};
        in_byp  = !q.req && en_x;
        if (wr_en) begin
            d.req = wr_data[BYP_BIT];
            if (wr_data[ERR_BIT]) begin
                d.err = 1'b0;
            end
            if (wr_cfg != q.cfg) begin
                if (in_byp) begin
                    d.cfg   = wr_cfg;
                    restart = 1'b1;
                end else begin
                    d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_xtal or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_w                        = '0;
        rd_w[BYP_BIT]               = q.req;
        rd_w[HALF_BIT]              = q.cfg.half;
        rd_w[REF_LSB +: DIV_W]      = q.cfg.refd;
        rd_w[FB_LSB  +: DIV_W]      = q.cfg.fbd;
        rd_w[VO_LSB  +: POST_W]     = q.cfg.vo;
        rd_w[CD_LSB  +: POST_W]     = q.cfg.cd;
        rd_w[ERR_BIT]               = q.err;
        rd_w[LOCK_BIT]              = locked;
    end

    assign rd_data   = rd_w;
    assign sel       = q.req & locked;
    assign cfg_bits  = q.cfg;
    assign unused_wr = ^{wr_data[LOCK_BIT], wr_data[ERR_BIT-1:TOP_FLD]};

    clksel_refdiv #(.DIV_W(DIV_W), .LOCK_CNT(LOCK_CNT)) u_ref (
        .clk      (clk_xtal),
        .rst_n    (rst_n),
        .half_sel (q.cfg.half),
        .ref_fld  (q.cfg.refd),
        .restart  (restart),
        .lock_raw (pll_lock_raw),
        .ref_tick (ref_tick),
        .ref_clk  (ref_clk_out),
        .locked   (locked)
    );

    clksel_vcodiv #(.DIV_W(DIV_W), .POST_W(POST_W)) u_vco (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .fb_fld  (q.cfg.fbd),
        .vo_fld  (q.cfg.vo),
        .cd_fld  (q.cfg.cd),
        .fb_clk  (fb_clk_out),
        .pll_clk (pll_clk)
    );

    clksel_gfmux u_mux (
        .xclk    (clk_xtal),
        .pclk    (pll_clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .clk_out (cpu_clk),
        .en_x    (en_x),
        .en_p    (en_p)
    );
endmodule

// File: rtl/clksel_ctrl_chk.sv
`timescale 1ns/1ps
module clksel_ctrl_chk #(
    parameter int DIV_W  = 6,
    parameter int POST_W = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            en_x,
    input logic                            en_p,
    input logic                            lock_flag,
    input logic                            err_flag,
    input logic                            wr_en,
    input logic                            ref_tick,
    input logic [1+2*DIV_W+2*POST_W-1:0]   cfg
);
    // R8: the two source enables are never on together
    assert_one_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_x && en_p));

    // R7: the PLL side is enabled only while lock is reported
    assert_switch_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_p) |-> lock_flag);

    // R9: divider settings cannot move while the crystal path is off
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_x |=> $stable(cfg));

    // R9: the error flag only rises in response to a write
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(wr_en));

    // R10: lock is declared only on a divided-reference step
    assert_lock_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(ref_tick));
endmodule

bind clksel_ctrl clksel_ctrl_chk #(.DIV_W(DIV_W), .POST_W(POST_W)) u_chk (
    .clk       (clk_xtal),
    .rst_n     (rst_n),
    .en_x      (en_x),
    .en_p      (en_p),
    .lock_flag (rd_data[31]),
    .err_flag  (rd_data[30]),
    .wr_en     (wr_en),
    .ref_tick  (ref_tick),
    .cfg       (cfg_bits)
);

// File: tb/tb_clksel_ctrl.sv
`timescale 1ns/1ps
module tb_clksel_ctrl;
    localparam int  LCK   = 16;
    localparam real XPER  = 8.0;
    localparam real VPER  = 3.0;
    // half, ref, fb, vo, cd, exp ref cycles, exp fb vco cycles, exp post vco cycles
    localparam int VEC [4][8] = '{
        '{0, 2, 5,  1, 2,  4,  7, 2},
        '{1, 2, 3,  2, 3,  8,  5, 6},
        '{0, 0, 0,  0, 0,  2,  2, 2},
        '{1, 7, 10, 3, 1, 18, 12, 3}
    };

    logic        clk_xtal = 1'b0;
    logic        clk_vco  = 1'b0;
    logic        rst_n    = 1'b0;
    logic        pll_lock_raw = 1'b0;
    logic        wr_en    = 1'b0;
    logic [31:0] wr_data  = '0;
    logic [31:0] rd_data;
    logic        ref_clk_out, fb_clk_out, cpu_clk;

    int checks = 0;
    int errors = 0;
    int runts  = 0;
    bit mon_on = 1'b0;
    realtime last_e = 0.0;

    always #4   clk_xtal = ~clk_xtal;
    always #1.5 clk_vco  = ~clk_vco;

    clksel_ctrl #(.LOCK_CNT(LCK)) dut (
        .clk_xtal(clk_xtal), .rst_n(rst_n), .clk_vco(clk_vco),
        .pll_lock_raw(pll_lock_raw), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ref_clk_out(ref_clk_out),
        .fb_clk_out(fb_clk_out), .cpu_clk(cpu_clk)
    );

    // runt monitor for R8
    always @(cpu_clk) begin
        if (mon_on && ($realtime - last_e) < 1.4) runts++;
        last_e = $realtime;
    end

    function automatic logic [31:0] pack(bit b, bit h, int r, int f, int vo, int cd);
        return 32'(b) | (32'(h) << 1) | (32'(r) << 2) | (32'(f) << 8)
             | (32'(vo) << 14) | (32'(cd) << 17);
    endfunction

    task automatic chk_int(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_real(string tag, real act, real exp);
        checks++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            errors++;
            $display("FAIL %s: actual %0.3f ns expected %0.3f ns", tag, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] v);
        @(negedge clk_xtal);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk_xtal);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic edge_of(int which);
        case (which)
            0: @(posedge ref_clk_out);
            1: @(posedge fb_clk_out);
            default: @(posedge cpu_clk);
        endcase
    endtask

    task automatic meas(int which, output real per);
        realtime t0;
        repeat (3) edge_of(which);
        t0 = $realtime;
        edge_of(which);
        per = $realtime - t0;
        @(negedge clk_xtal);
    endtask

    task automatic wait_lock();
        for (int k = 0; k < 4000 && !rd_data[31]; k++) @(negedge clk_xtal);
    endtask

    initial begin
        repeat (150000) @(posedge clk_xtal);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        real p;
        repeat (10) @(negedge clk_xtal);
        rst_n = 1'b1;
        @(negedge clk_xtal);
        mon_on = 1'b1;
        chk_int("R1 reset readback", rd_data, 0);
        meas(2, p); chk_real("R1 reset cpu period", p, XPER);
        pll_lock_raw = 1'b1;
        repeat (4) @(negedge clk_xtal);

        // vector table walk
        for (int i = 0; i < 4; i++) begin
            wr(pack(0, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]));
            chk_int("R11 R10 readback after accepted write", rd_data,
                    pack(0, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]));
            meas(0, p);
            chk_real(VEC[i][0] ? "R2 halved reference period" : "R3 reference period",
                     p, real'(VEC[i][5]) * XPER);
            meas(1, p); chk_real("R4 feedback period", p, real'(VEC[i][6]) * VPER);
            wr(pack(1, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]));
            wait_lock();
            chk_int("R7 lock flag reached", rd_data[31], 1);
            repeat (10) @(negedge clk_xtal);
            meas(2, p); chk_real("R5 pll cpu period", p, real'(VEC[i][7]) * VPER);
            wr(pack(0, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]));
            repeat (10) @(negedge clk_xtal);
            meas(2, p); chk_real("R6 bypass cpu period", p, XPER);
        end

        // deferred switch without lock
        pll_lock_raw = 1'b0;
        wr(pack(0, 0, 2, 5, 1, 2));
        wr(pack(1, 0, 2, 5, 1, 2));
        repeat (50) @(negedge clk_xtal);
        chk_int("R7 no lock while raw low", rd_data[31], 0);
        meas(2, p); chk_real("R7 crystal held until lock", p, XPER);
        pll_lock_raw = 1'b1;
        wait_lock();
        repeat (10) @(negedge clk_xtal);
        meas(2, p); chk_real("R7 switched after lock", p, 2.0 * VPER);

        // rejected write while PLL active
        wr(pack(1, 1, 3, 4, 2, 2));
        chk_int("R9 fields kept error set", rd_data,
                pack(1, 0, 2, 5, 1, 2) | 32'hC000_0000);
        meas(2, p); chk_real("R9 cpu period unchanged", p, 2.0 * VPER);
        wr(pack(1, 0, 2, 5, 1, 2) | 32'h4000_0000);
        chk_int("R9 error cleared by write one", rd_data[30], 0);

        // exact lock boundary after reprogram
        wr(pack(0, 0, 2, 5, 1, 2));
        repeat (10) @(negedge clk_xtal);
        wr(pack(0, 0, 2, 5, 2, 2));
        chk_int("R10 lock cleared at once", rd_data[31], 0);
        repeat (LCK * 4 - 1) @(negedge clk_xtal);
        chk_int("R10 lock not yet due", rd_data[31], 0);
        @(negedge clk_xtal);
        chk_int("R10 lock due edge", rd_data[31], 1);

        // reprogram then immediate return to PLL
        wr(pack(0, 0, 2, 5, 3, 1));
        wr(pack(1, 0, 2, 5, 3, 1));
        meas(2, p); chk_real("R7 return deferred until relock", p, XPER);
        wait_lock();
        repeat (10) @(negedge clk_xtal);
        meas(2, p); chk_real("R5 odd post factor", p, 3.0 * VPER);

        // lock loss falls back to crystal
        pll_lock_raw = 1'b0;
        repeat (10) @(negedge clk_xtal);
        chk_int("R7 lock flag drops", rd_data[31], 0);
        meas(2, p); chk_real("R7 fallback to crystal", p, XPER);

        chk_int("R8 runt pulses", runts, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule